// File: doc/BRIEF.md
# Remote Write Bus Arbiter

This block decides who owns a shared memory bus: the local CPU's timing unit or a remote processor that posts buffered writes. While idle it hands the bus to the timing unit on request. A remote write request is the remote enable ANDed with the remote write strobe. When one arrives, the block pulls the active-low remote acknowledge low at once. This tells the remote side to wait. The block takes the bus only when no local request is pending and the lock-out bit is clear.

Once the block owns the bus, it floats the local address and data drivers and loads two wait counters from configuration fields. It then routes the write to one of five targets, using a command bit and a two-bit memory-select field. The targets are a control register, the program-counter low byte, the program-counter high byte, data memory, and instruction memory. Instruction words arrive low byte first. The low byte goes to a holding latch, and the high byte starts the real instruction-memory write.

After the write, the block releases the acknowledge. It waits for the remote side to drop its request and for the external ready input. It then passes through one final floating cycle before returning to idle. All interface pins are plain level signals, because no data stream passes through this block.

Top module: `rbus_arbiter`

## Requirements
- R1: A synchronous active-high `rst` forces idle. While `rst` is high, `ack_n` is 1, `bus_hiz` is 0, `loc_gnt` is 0 and all write strobes are 0. Reset also clears the byte-order flag, so the next instruction-memory write is treated as a low byte.
- R2: In idle, `loc_gnt` follows `loc_req` in the same cycle. In every other state, `loc_gnt` is 0, and `tcu_hold` equals `loc_req`.
- R3: In idle, `ack_n` is low in the same cycle whenever `rem_en & rem_wr` is 1, even if `loc_req` is 1. `ack_n` stays low in the setup and access states.
- R4: Idle is left on a clock edge only when `rem_en & rem_wr` is 1, `loc_req` is 0 and `lockout` is 0. While `lockout` is 1, or while `rem_en` is 0, the block stays idle and `bus_hiz` stays 0.
- R5: The first state after idle lasts exactly one cycle. In it, `bus_hiz` is 1 and no write strobe is active. The counters are loaded from `iwait_cfg` and `dwait_cfg`, and `cmd`/`msel` are captured for the decode.
- R6: Decode is as follows. `cmd`=1 selects `ctl_wr` whatever `msel` holds. With `cmd`=0, `msel`=2'b10 selects `pcl_wr`, 2'b11 selects `pch_wr`, 2'b00 selects `dmem_wr`, and 2'b01 selects instruction memory. At most one strobe is active at a time.
- R7: A data-memory access holds its strobe for `dwait_cfg`+1 cycles, and an instruction-memory access for `iwait_cfg`+1 cycles. A count of 0 gives a single cycle. The other targets always take one cycle.
- R8: An instruction-memory access raises `ilat_ld` when the byte-order flag is 0 and `imem_wr` when it is 1. The flag toggles in the final state of each instruction-memory access. `pc_inc` pulses for that one cycle when the access was a high byte.
- R9: After the access, `ack_n` is 1 and `bus_hiz` stays 1. The block remains there until `rem_en & rem_wr` is 0 and `ext_wait` is 1.
- R10: The final state lasts one cycle with `bus_hiz` at 1. Then the block is idle and `bus_hiz` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| rem_en | input | 1 | Remote access enable |
| rem_wr | input | 1 | Remote write strobe |
| ext_wait | input | 1 | External ready; 1 lets termination finish |
| cmd | input | 1 | 1 selects the control register |
| msel | input | 2 | Memory select |
| lockout | input | 1 | Config bit that keeps the remote side out |
| iwait_cfg | input | 2 | Instruction-memory wait count |
| dwait_cfg | input | 3 | Data-memory wait count |
| loc_req | input | 1 | Local bus request from the timing unit |
| loc_gnt | output | 1 | Local bus grant |
| tcu_hold | output | 1 | Holds the timing unit in a wait state |
| ack_n | output | 1 | Remote acknowledge, low means wait |
| bus_hiz | output | 1 | Local address/data drivers floated |
| ctl_wr | output | 1 | Control register write |
| pcl_wr | output | 1 | Program-counter low byte write |
| pch_wr | output | 1 | Program-counter high byte write |
| dmem_wr | output | 1 | Data-memory write strobe |
| ilat_ld | output | 1 | Instruction low-byte latch load |
| imem_wr | output | 1 | Instruction-memory write |
| pc_inc | output | 1 | Program-counter increment pulse |

## Verification
A vector table drives every `cmd`/`msel` combination through a complete write cycle. It includes `cmd`=1 with a memory-select value that would otherwise pick instruction memory, which shows whether the command bit takes priority. Data and instruction wait counts of 0, mid-range values and the maximum are timed by strobe length, so a fencepost error in either counter shows up. Alternating instruction writes separate the low-byte latch path from the high-byte write, and check that `pc_inc` appears only after a high byte. Directed runs cover the remaining paths: lock-out, a pending local request, a disabled remote side, a held external ready, and clearing the byte-order flag by reset in the middle of a word.

// File: rtl/rbus_pkg.sv
package rbus_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_SETUP, ST_ACCESS, ST_TERM, ST_FINAL
  } rb_state_e;

  typedef enum logic [2:0] {
    TG_CTL, TG_PCL, TG_PCH, TG_DMEM, TG_IMEM
  } rb_tgt_e;
endpackage

// File: rtl/rbus_wait_ctr.sv
module rbus_wait_ctr #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] init,
  input  logic         dec,
  output logic         zero
);
  logic [W-1:0] cnt;

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (load)            cnt <= init;
    else if (dec && cnt != 0) cnt <= cnt - W'(1);
  end

  assign zero = (cnt == '0);

  // R7: each wait cycle removes exactly one count
  assert_ctr_step_R7: assert property (@(posedge clk) disable iff (rst)
    (!load && dec && !zero) |=> (cnt == $past(cnt) - W'(1)));
  // R7: a loaded value is visible on the next cycle
  assert_ctr_load_R7: assert property (@(posedge clk) disable iff (rst)
    load |=> (cnt == $past(init)));
endmodule

// File: rtl/rbus_tgt_dec.sv
module rbus_tgt_dec
  import rbus_pkg::*;
(
  input  logic       cmd,
  input  logic [1:0] msel,
  output rb_tgt_e    tgt
);
  always_comb begin
    if (cmd) tgt = TG_CTL;
    else begin
      case (msel)
        2'b00:   tgt = TG_DMEM;
        2'b01:   tgt = TG_IMEM;
        2'b10:   tgt = TG_PCL;
        default: tgt = TG_PCH;
      endcase
    end
  end
endmodule

// File: rtl/rbus_arbiter.sv
module rbus_arbiter
  import rbus_pkg::*;
#(
  parameter int IW_W = 2,
  parameter int DW_W = 3
) (
  input  logic            clk,
  input  logic            rst,
  input  logic            rem_en,
  input  logic            rem_wr,
  input  logic            ext_wait,
  input  logic            cmd,
  input  logic [1:0]      msel,
  input  logic            lockout,
  input  logic [IW_W-1:0] iwait_cfg,
  input  logic [DW_W-1:0] dwait_cfg,
  input  logic            loc_req,
  output logic            loc_gnt,
  output logic            tcu_hold,
  output logic            ack_n,
  output logic            bus_hiz,
  output logic            ctl_wr,
  output logic            pcl_wr,
  output logic            pch_wr,
  output logic            dmem_wr,
  output logic            ilat_ld,
  output logic            imem_wr,
  output logic            pc_inc
);
  rb_state_e state, nxt;
  rb_tgt_e   tgt_dec, tgt_q;
  logic      hib;
  logic      req, idle, access_done;
  logic      i_zero, d_zero, ctr_load;

  assign req  = rem_en & rem_wr;
  assign idle = (state == ST_IDLE);

  rbus_tgt_dec u_dec (.cmd(cmd), .msel(msel), .tgt(tgt_dec));

  assign ctr_load = (state == ST_SETUP);

  rbus_wait_ctr #(.W(IW_W)) u_ictr (
    .clk(clk), .rst(rst), .load(ctr_load), .init(iwait_cfg),
    .dec(state == ST_ACCESS && tgt_q == TG_IMEM), .zero(i_zero));

  rbus_wait_ctr #(.W(DW_W)) u_dctr (
    .clk(clk), .rst(rst), .load(ctr_load), .init(dwait_cfg),
    .dec(state == ST_ACCESS && tgt_q == TG_DMEM), .zero(d_zero));

  always_comb begin
    case (tgt_q)
      TG_DMEM: access_done = d_zero;
      TG_IMEM: access_done = i_zero;
      default: access_done = 1'b1;
    endcase
  end

  always_comb begin
    nxt = state;
    case (state)
      ST_IDLE:   if (req && !loc_req && !lockout) nxt = ST_SETUP;
      ST_SETUP:  nxt = ST_ACCESS;
      ST_ACCESS: if (access_done) nxt = ST_TERM;
      ST_TERM:   if (!req && ext_wait) nxt = ST_FINAL;
      ST_FINAL:  nxt = ST_IDLE;
      default:   nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state <= ST_IDLE;
      tgt_q <= TG_CTL;
      hib   <= 1'b0;
    end else begin
      state <= nxt;
      if (state == ST_SETUP) tgt_q <= tgt_dec;
      if (state == ST_FINAL && tgt_q == TG_IMEM) hib <= ~hib;
    end
  end

  // bus ownership and handshake
  assign loc_gnt  = idle & loc_req & ~rst;
  assign tcu_hold = ~idle & loc_req;
  assign bus_hiz  = ~idle;
  always_comb begin
    case (state)
      ST_IDLE:             ack_n = ~(req & ~rst);
      ST_SETUP, ST_ACCESS: ack_n = 1'b0;
      default:             ack_n = 1'b1;
    endcase
  end

  // target write strobes
  logic in_acc;
  assign in_acc  = (state == ST_ACCESS);
  assign ctl_wr  = in_acc && tgt_q == TG_CTL;
  assign pcl_wr  = in_acc && tgt_q == TG_PCL;
  assign pch_wr  = in_acc && tgt_q == TG_PCH;
  assign dmem_wr = in_acc && tgt_q == TG_DMEM;
  assign ilat_ld = in_acc && tgt_q == TG_IMEM && !hib;
  assign imem_wr = in_acc && tgt_q == TG_IMEM && hib;
  assign pc_inc  = (state == ST_FINAL) && tgt_q == TG_IMEM && hib;

  // ---------------- assertions ----------------
  assert_no_busy_grant_R2: assert property (@(posedge clk) disable iff (rst)
    !idle |-> !loc_gnt);
  assert_lockout_hold_R4: assert property (@(posedge clk) disable iff (rst)
    (idle && lockout) |=> idle);
  assert_local_first_R4: assert property (@(posedge clk) disable iff (rst)
    (idle && loc_req) |=> idle);
  assert_setup_single_R5: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETUP) |=> (state == ST_ACCESS));
  assert_ack_wait_R3: assert property (@(posedge clk) disable iff (rst)
    (state == ST_SETUP || state == ST_ACCESS) |-> !ack_n);
  assert_one_strobe_R6: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctl_wr, pcl_wr, pch_wr, dmem_wr, ilat_ld, imem_wr}));
  assert_hib_flip_R8: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINAL && tgt_q == TG_IMEM) |=> (hib != $past(hib)));
  assert_term_ack_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TERM) |-> (ack_n && bus_hiz));
  assert_term_hold_R9: assert property (@(posedge clk) disable iff (rst)
    (state == ST_TERM && req) |=> (state == ST_TERM));
  assert_final_once_R10: assert property (@(posedge clk) disable iff (rst)
    (state == ST_FINAL) |=> idle);
endmodule

// File: tb/rbus_arbiter_test.sv
module rbus_arbiter_test;
  logic clk = 0, rst = 1;
  logic rem_en = 0, rem_wr = 0, ext_wait = 1, cmd = 0, lockout = 0, loc_req = 0;
  logic [1:0] msel = 0, iwait_cfg = 0;
  logic [2:0] dwait_cfg = 0;
  logic loc_gnt, tcu_hold, ack_n, bus_hiz;
  logic ctl_wr, pcl_wr, pch_wr, dmem_wr, ilat_ld, imem_wr, pc_inc;
  int total = 0, fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  rbus_arbiter uut (.*);

  // strobe order {ilat_ld, imem_wr, dmem_wr, pch_wr, pcl_wr, ctl_wr}
  function automatic logic [5:0] stb();
    return {ilat_ld, imem_wr, dmem_wr, pch_wr, pcl_wr, ctl_wr};
  endfunction

  task automatic chk(input string r, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s act=%0d exp=%0d", r, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  endtask

  // fields: cmd, msel[2], iw[2], dw[3], mask[6], cycles[4], pcinc
  localparam int NV = 11;
  localparam logic [18:0] VEC [NV] = '{
    {1'b1, 2'b00, 2'd3, 3'd7, 6'b000001, 4'd1, 1'b0},
    {1'b1, 2'b01, 2'd3, 3'd7, 6'b000001, 4'd1, 1'b0},
    {1'b0, 2'b10, 2'd3, 3'd7, 6'b000010, 4'd1, 1'b0},
    {1'b0, 2'b11, 2'd3, 3'd7, 6'b000100, 4'd1, 1'b0},
    {1'b0, 2'b00, 2'd3, 3'd0, 6'b001000, 4'd1, 1'b0},
    {1'b0, 2'b00, 2'd0, 3'd5, 6'b001000, 4'd6, 1'b0},
    {1'b0, 2'b00, 2'd0, 3'd7, 6'b001000, 4'd8, 1'b0},
    {1'b0, 2'b01, 2'd0, 3'd7, 6'b100000, 4'd1, 1'b0},
    {1'b0, 2'b01, 2'd2, 3'd0, 6'b010000, 4'd3, 1'b1},
    {1'b0, 2'b01, 2'd3, 3'd0, 6'b100000, 4'd4, 1'b0},
    {1'b0, 2'b01, 2'd1, 3'd6, 6'b010000, 4'd2, 1'b1}
  };

  initial begin
    repeat (100000) @(posedge clk);
    total++; fails++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    // R1: reset state, even with a request and local request present
    rem_en = 1; rem_wr = 1; loc_req = 1;
    tick(); tick();
    chk("R1 ack_n", ack_n, 1);
    chk("R1 bus_hiz", bus_hiz, 0);
    chk("R1 loc_gnt", loc_gnt, 0);
    chk("R1 strobes", stb(), 0);
    rem_en = 0; rem_wr = 0; loc_req = 0; rst = 0;
    tick();

    // vector table
    for (int k = 0; k < NV; k++) begin
      logic [18:0] v;
      logic [5:0]  mask;
      int n;
      v = VEC[k];
      cmd = v[18]; msel = v[17:16]; iwait_cfg = v[15:14]; dwait_cfg = v[13:11];
      mask = v[10:5];
      rem_en = 1; rem_wr = 1; #1;
      chk("R3 ack low in idle", ack_n, 0);
      tick();
      chk("R5 setup hiz", bus_hiz, 1);
      chk("R5 setup no strobe", stb(), 0);
      chk("R3 ack low in setup", ack_n, 0);
      tick();
      chk("R6 target strobe", stb(), mask);
      n = 0;
      while (stb() == mask && n < 20) begin n++; tick(); end
      chk("R7 access length", n, v[4:1]);
      chk("R9 ack released", ack_n, 1);
      tick();
      chk("R9 held while request", bus_hiz, 1);
      rem_wr = 0;
      tick();
      chk("R10 final hiz", bus_hiz, 1);
      chk("R8 pc_inc", pc_inc, v[0]);
      tick();
      chk("R10 back to idle", bus_hiz, 0);
      rem_en = 0;
    end

    // R4: lock-out keeps the block idle; R2 grant still given
    lockout = 1; rem_en = 1; rem_wr = 1;
    repeat (4) tick();
    chk("R4 lockout idle", bus_hiz, 0);
    chk("R3 ack low under lockout", ack_n, 0);
    loc_req = 1; #1;
    chk("R2 idle grant", loc_gnt, 1);
    lockout = 0;
    // R4: pending local request defers the remote side
    tick(); tick();
    chk("R4 local first", bus_hiz, 0);
    chk("R3 ack low with local", ack_n, 0);
    chk("R2 grant kept", loc_gnt, 1);
    loc_req = 0; cmd = 1;
    tick();
    chk("R4 leave idle", bus_hiz, 1);
    loc_req = 1; #1;
    chk("R2 no grant busy", loc_gnt, 0);
    chk("R2 hold timing unit", tcu_hold, 1);
    loc_req = 0;
    tick(); tick();
    // R9: external wait low holds termination
    rem_wr = 0; ext_wait = 0;
    repeat (3) tick();
    chk("R9 ext_wait hold", bus_hiz, 1);
    ext_wait = 1;
    tick();
    chk("R10 final", bus_hiz, 1);
    tick();
    chk("R10 idle", bus_hiz, 0);

    // R4: enable low gates the strobe
    rem_en = 0; rem_wr = 1;
    tick(); tick();
    chk("R4 disabled idle", bus_hiz, 0);
    chk("R4 disabled ack", ack_n, 1);

    // R1: reset clears the byte-order flag mid-word
    cmd = 0; msel = 2'b01; iwait_cfg = 0; rem_en = 1;
    tick(); tick();
    chk("R8 low byte first", ilat_ld, 1);
    rem_wr = 0;
    tick(); tick(); tick();
    rst = 1; tick(); rst = 0; tick();
    rem_wr = 1;
    tick(); tick();
    chk("R1 flag cleared", ilat_ld, 1);
    rem_wr = 0; rem_en = 0;
    repeat (4) tick();
    finish_run();
  end
endmodule